// File: doc/BRIEF.md
# Memory-Map Decoder with Bus-Cycle Stretch

This block sits on a 16-bit-address microcontroller bus and decides, for every access, which single resource answers it: the on-chip register block, RAM, EEPROM, the debug ROM, flash, a 512-byte slow region that follows the registers, or off-chip space. It also holds the bus ready line low for a programmable number of extra bus clocks when the access goes off-chip. The memory arrays themselves are outside the block. Only chip selects and a ready line come out.

A six-bit configuration word sets four things: two stretch counts (one for the slow region, one for general off-chip space), flash enable, and flash placement in the lower or upper half of the map. Stretching and off-chip decoding apply only in expanded mode. In single-chip and peripheral modes the bus never waits. At reset the flash bits take a value that depends on the operating mode, and both stretch counts start at their maximum so that slow devices work before software sets up the bus.

The access sequencer is a two-state machine. `ST_IDLE` waits for a strobe. The `IDLE->BUSY` transition is taken on a strobe, and it latches the target and the stretch count. `ST_BUSY` counts the count down to zero. The `BUSY->BUSY` transition decrements the count. The `BUSY->IDLE` transition is taken when the count is zero, and that is the cycle in which the access ends.

Top module: `memmap_stretch_ctl`

## Requirements
- R1: After reset, ready_o is 1 and sel_o is 0. Both stretch fields reset to code 11. Flash enable and flash placement reset to 1 when mode_i is 00 (single-chip) at reset, and to 0 for any other mode.
- R2: The internal windows are registers 0x0000-0x01FF, RAM 0x0800-0x0BFF, EEPROM 0x0D00-0x0FFF and debug ROM 0xFF00-0xFFFF. They are claimed in this fixed priority: registers, then RAM, then EEPROM, then debug ROM, then flash. At most one sel_o bit is ever high. The sel_o bits are: 0 registers, 1 RAM, 2 EEPROM, 3 debug ROM, 4 flash, 5 slow region, 6 off-chip.
- R3: With flash enabled and placement 1, flash covers 0x8000-0xFFFF. With placement 0, it covers 0x0000-0x7FFF. With flash disabled, flash is never selected and the placement bit has no effect.
- R4: mode_i encodes 00 single-chip, 01 expanded, 10 peripheral, and 11 behaves as peripheral. In expanded mode, an unclaimed address in 0x0200-0x03FF selects the slow region, and any other unclaimed address selects off-chip space. In the other modes an unclaimed address asserts no select.
- R5: A cycle with cfg_we_i high loads cfg_wdata_i. Bits [1:0] are the slow-region stretch, [3:2] the off-chip stretch, [4] the flash placement and [5] the flash enable.
- R6: A strobe accepted while idle asserts the target's select from the next cycle. ready_o is then low for exactly N cycles and high in the last access cycle. The select stays constant for the whole access and drops in the cycle after.
- R7: In expanded mode, N is the slow-region field for slow-region accesses and the off-chip field for off-chip accesses. Codes 00, 01, 10 and 11 give 0, 1, 2 and 3.
- R8: In every mode other than expanded, N is 0 whatever the stretch fields hold.
- R9: A strobe that arrives while an access is in progress is ignored. It starts no access and changes no select.
- R10: With dbg_act_i low, the debug ROM window is not claimed, and its addresses fall through to flash or to the unclaimed rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Operating mode |
| dbg_act_i | input | 1 | Debug ROM is active |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_wdata_i | input | 6 | Configuration write data |
| acc_req_i | input | 1 | Access strobe |
| addr_i | input | 16 | Access address |
| sel_o | output | 7 | One-hot chip selects |
| ready_o | output | 1 | Bus ready; low while stretching |

## Verification
The hardest situation to reach is a strobe that lands in the middle of a stretched access. The bench provokes it directly. It sets the off-chip stretch to three and starts an off-chip access. During a wait cycle it pulses the strobe again with a RAM address, then drops the strobe before the access ends. It then checks that the select stays on off-chip and that the bus idles afterwards.

Reset-dependent flash placement also needs its own stimulus. The bench resets the block under both single-chip and expanded modes and probes the upper half of the map before writing any configuration.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE   = 2'b00,
        MODE_EXPANDED = 2'b01,
        MODE_PERIPH   = 2'b10,
        MODE_RSVD     = 2'b11
    } op_mode_e;

    localparam int NUM_TGT = 7;
    localparam int CNT_W   = 2;

    typedef enum logic [2:0] {
        T_REGS  = 3'd0,
        T_RAM   = 3'd1,
        T_EEP   = 3'd2,
        T_DBG   = 3'd3,
        T_FLASH = 3'd4,
        T_SLOW  = 3'd5,
        T_EXT   = 3'd6,
        T_NONE  = 3'd7
    } tgt_e;

    typedef struct packed {
        logic             flash_en;
        logic             flash_hi;
        logic [CNT_W-1:0] ext_wait;
        logic [CNT_W-1:0] slow_wait;
    } bus_cfg_t;

endpackage

// File: rtl/mmap_cfg_reg.sv
module mmap_cfg_reg
    import mmap_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  op_mode_e mode_i,
    input  logic     we_i,
    input  bus_cfg_t wdata_i,
    output bus_cfg_t cfg_o
);

    localparam logic [CNT_W-1:0] WAIT_MAX = {CNT_W{1'b1}};

    // Flash bits take a mode-dependent value, so the reset is synchronous.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o.slow_wait <= WAIT_MAX;
            cfg_o.ext_wait  <= WAIT_MAX;
            cfg_o.flash_en  <= (mode_i == MODE_SINGLE);
            cfg_o.flash_hi  <= (mode_i == MODE_SINGLE);
        end else if (we_i) begin
            cfg_o <= wdata_i;
        end
    end

endmodule

// File: rtl/mmap_decode.sv
module mmap_decode
    import mmap_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int REG_BASE  = 'h0000,
    parameter int REG_SIZE  = 'h0200,
    parameter int RAM_BASE  = 'h0800,
    parameter int RAM_SIZE  = 'h0400,
    parameter int EEP_BASE  = 'h0D00,
    parameter int EEP_SIZE  = 'h0300,
    parameter int DBG_BASE  = 'hFF00,
    parameter int DBG_SIZE  = 'h0100,
    parameter int SLOW_BASE = 'h0200,
    parameter int SLOW_SIZE = 'h0200
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  op_mode_e          mode_i,
    input  logic              dbg_act_i,
    input  bus_cfg_t          cfg_i,
    output tgt_e              tgt_o,
    output logic [CNT_W-1:0]  wait_o
);

    localparam int NUM_WIN = 4;
    localparam int WIN_LO [NUM_WIN] = '{REG_BASE, RAM_BASE, EEP_BASE, DBG_BASE};
    localparam int WIN_HI [NUM_WIN] = '{REG_BASE + REG_SIZE - 1, RAM_BASE + RAM_SIZE - 1,
                                        EEP_BASE + EEP_SIZE - 1, DBG_BASE + DBG_SIZE - 1};
    localparam int SLOW_HI = SLOW_BASE + SLOW_SIZE - 1;

    logic [NUM_WIN-1:0] win_hit;
    logic               flash_hit;
    logic               slow_hit;
    logic               expanded;
    int                 a_int;

    assign a_int    = int'(addr_i);
    assign expanded = (mode_i == MODE_EXPANDED);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        if (w == int'(T_DBG)) begin : g_gated
            assign win_hit[w] = dbg_act_i && (a_int >= WIN_LO[w]) && (a_int <= WIN_HI[w]);
        end else begin : g_plain
            assign win_hit[w] = (a_int >= WIN_LO[w]) && (a_int <= WIN_HI[w]);
        end
    end

    assign flash_hit = cfg_i.flash_en && (addr_i[ADDR_W-1] == cfg_i.flash_hi);
    assign slow_hit  = (a_int >= SLOW_BASE) && (a_int <= SLOW_HI);

    always_comb begin
        if (win_hit[0])      tgt_o = T_REGS;
        else if (win_hit[1]) tgt_o = T_RAM;
        else if (win_hit[2]) tgt_o = T_EEP;
        else if (win_hit[3]) tgt_o = T_DBG;
        else if (flash_hit)  tgt_o = T_FLASH;
        else if (!expanded)  tgt_o = T_NONE;
        else if (slow_hit)   tgt_o = T_SLOW;
        else                 tgt_o = T_EXT;
    end

    always_comb begin
        unique case (tgt_o)
            T_SLOW:  wait_o = cfg_i.slow_wait;
            T_EXT:   wait_o = cfg_i.ext_wait;
            default: wait_o = '0;
        endcase
    end

endmodule

// File: rtl/mmap_stretch_fsm.sv
module mmap_stretch_fsm
    import mmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [CNT_W-1:0]   wait_i,
    input  tgt_e               tgt_i,
    output logic [NUM_TGT-1:0] sel_o,
    output logic               ready_o,
    output logic               busy_o
);

    typedef enum logic {ST_IDLE, ST_BUSY} st_e;

    st_e              st;
    logic [CNT_W-1:0] cnt;
    tgt_e             tgt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            tgt_q <= T_NONE;
        end else begin
            unique case (st)
                ST_IDLE: if (start_i) begin
                    st    <= ST_BUSY;
                    cnt   <= wait_i;
                    tgt_q <= tgt_i;
                end
                ST_BUSY: if (cnt == '0) st <= ST_IDLE;
                         else           cnt <= cnt - 1'b1;
            endcase
        end
    end

    always_comb begin
        busy_o  = (st == ST_BUSY);
        ready_o = !(busy_o && (cnt != '0));
        for (int i = 0; i < NUM_TGT; i++) begin
            sel_o[i] = busy_o && (int'(tgt_q) == i);
        end
    end

endmodule

// File: rtl/memmap_stretch_ctl.sv
module memmap_stretch_ctl
    import mmap_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int REG_BASE  = 'h0000,
    parameter int REG_SIZE  = 'h0200,
    parameter int RAM_BASE  = 'h0800,
    parameter int RAM_SIZE  = 'h0400,
    parameter int EEP_BASE  = 'h0D00,
    parameter int EEP_SIZE  = 'h0300,
    parameter int DBG_BASE  = 'hFF00,
    parameter int DBG_SIZE  = 'h0100,
    parameter int SLOW_BASE = 'h0200,
    parameter int SLOW_SIZE = 'h0200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_i,
    input  logic               dbg_act_i,
    input  logic               cfg_we_i,
    input  logic [5:0]         cfg_wdata_i,
    input  logic               acc_req_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [NUM_TGT-1:0] sel_o,
    output logic               ready_o
);

    op_mode_e         mode;
    bus_cfg_t         cfg;
    tgt_e             tgt;
    logic [CNT_W-1:0] wait_n;
    logic             busy;

    assign mode = op_mode_e'(mode_i);

    mmap_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode),
        .we_i    (cfg_we_i),
        .wdata_i (bus_cfg_t'(cfg_wdata_i)),
        .cfg_o   (cfg)
    );

    mmap_decode #(
        .ADDR_W    (ADDR_W),
        .REG_BASE  (REG_BASE),  .REG_SIZE  (REG_SIZE),
        .RAM_BASE  (RAM_BASE),  .RAM_SIZE  (RAM_SIZE),
        .EEP_BASE  (EEP_BASE),  .EEP_SIZE  (EEP_SIZE),
        .DBG_BASE  (DBG_BASE),  .DBG_SIZE  (DBG_SIZE),
        .SLOW_BASE (SLOW_BASE), .SLOW_SIZE (SLOW_SIZE)
    ) u_dec (
        .addr_i    (addr_i),
        .mode_i    (mode),
        .dbg_act_i (dbg_act_i),
        .cfg_i     (cfg),
        .tgt_o     (tgt),
        .wait_o    (wait_n)
    );

    mmap_stretch_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (acc_req_i),
        .wait_i  (wait_n),
        .tgt_i   (tgt),
        .sel_o   (sel_o),
        .ready_o (ready_o),
        .busy_o  (busy)
    );

endmodule

// File: rtl/mmap_stretch_chk.sv
module mmap_stretch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       acc_req_i,
    input logic [6:0] sel_o,
    input logic       ready_o,
    input logic       busy
);

    logic [2:0] low_run;

    always_ff @(posedge clk) begin
        if (!rst_n)        low_run <= '0;
        else if (!ready_o) low_run <= low_run + 3'd1;
        else               low_run <= '0;
    end

    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));

    a_r8_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && acc_req_i && mode_i != 2'b01) |=> ready_o);

    a_r6_ends_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ready_o) |=> !busy);

    a_r9_hold_target: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ready_o) |=> (busy && $stable(sel_o)));

    a_r7_max_three: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> (low_run < 3'd3));

endmodule

bind memmap_stretch_ctl mmap_stretch_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .acc_req_i (acc_req_i),
    .sel_o     (sel_o),
    .ready_o   (ready_o),
    .busy      (busy)
);

// File: tb/sim_memmap_stretch_ctl.sv
module sim_memmap_stretch_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'b01;
    logic        dbg_act_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [5:0]  cfg_wdata_i = '0;
    logic        acc_req_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [6:0]  sel_o;
    logic        ready_o;

    int n_chk = 0;
    int n_bad = 0;
    bit hung  = 1'b0;

    always #5 clk = ~clk;

    memmap_stretch_ctl u0 (.*);

    // vector: mode[25:24] en[23] hi[22] dbg[21] addr[20:5] tgt[4:2] wait[1:0]
    localparam int NV = 18;
    localparam logic [25:0] VEC [NV] = '{
        {2'd0, 1'b1, 1'b1, 1'b0, 16'h0010, 3'd0, 2'd0},
        {2'd0, 1'b1, 1'b1, 1'b0, 16'h8000, 3'd4, 2'd0},
        {2'd0, 1'b1, 1'b0, 1'b0, 16'h8000, 3'd7, 2'd0},
        {2'd0, 1'b1, 1'b0, 1'b0, 16'h0900, 3'd1, 2'd0},
        {2'd1, 1'b0, 1'b0, 1'b0, 16'h0300, 3'd5, 2'd1},
        {2'd1, 1'b0, 1'b0, 1'b0, 16'h4000, 3'd6, 2'd2},
        {2'd1, 1'b1, 1'b0, 1'b0, 16'h0300, 3'd4, 2'd0},
        {2'd1, 1'b1, 1'b1, 1'b1, 16'hFF80, 3'd3, 2'd0},
        {2'd1, 1'b1, 1'b1, 1'b0, 16'hFF80, 3'd4, 2'd0},
        {2'd1, 1'b0, 1'b1, 1'b1, 16'hFF80, 3'd3, 2'd0},
        {2'd1, 1'b0, 1'b1, 1'b0, 16'hFFFF, 3'd6, 2'd2},
        {2'd2, 1'b0, 1'b0, 1'b0, 16'h0300, 3'd7, 2'd0},
        {2'd2, 1'b1, 1'b0, 1'b0, 16'h0E00, 3'd2, 2'd0},
        {2'd1, 1'b1, 1'b0, 1'b0, 16'h0C00, 3'd4, 2'd0},
        {2'd1, 1'b1, 1'b1, 1'b0, 16'h0200, 3'd5, 2'd1},
        {2'd3, 1'b0, 1'b0, 1'b0, 16'h4000, 3'd7, 2'd0},
        {2'd1, 1'b0, 1'b0, 1'b0, 16'h01FF, 3'd0, 2'd0},
        {2'd1, 1'b0, 1'b0, 1'b0, 16'h0BFF, 3'd1, 2'd0}
    };

    localparam logic [15:0] PROBE [8] = '{16'h0000, 16'h0250, 16'h0A00, 16'h0D00,
                                          16'h1234, 16'h7FFF, 16'h8000, 16'hFF00};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_tgt(input logic [1:0] m, input bit en, input bit hi,
                                   input bit dbg, input logic [15:0] a);
        if (a <= 16'h01FF) return 0;
        if (a >= 16'h0800 && a <= 16'h0BFF) return 1;
        if (a >= 16'h0D00 && a <= 16'h0FFF) return 2;
        if (dbg && a >= 16'hFF00) return 3;
        if (en && a[15] == hi) return 4;
        if (m != 2'b01) return 7;
        if (a >= 16'h0200 && a <= 16'h03FF) return 5;
        return 6;
    endfunction

    function automatic int sel_idx(input logic [6:0] s);
        for (int i = 0; i < 7; i++) if (s[i]) return i;
        return 7;
    endfunction

    task automatic cfg_write(input logic [5:0] d);
        cfg_wdata_i = d;
        cfg_we_i    = 1'b1;
        @(negedge clk);
        cfg_we_i    = 1'b0;
    endtask

    task automatic do_reset(input logic [1:0] m);
        mode_i = m;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        @(negedge clk);
    endtask

    // Runs one access and returns the selected target index and the wait count.
    task automatic access(input logic [15:0] a, output int tgt, output int waits);
        logic [6:0] first;
        addr_i    = a;
        acc_req_i = 1'b1;
        @(negedge clk);
        acc_req_i = 1'b0;
        first = sel_o;
        tgt   = sel_idx(sel_o);
        waits = 0;
        while (!ready_o && waits < 8) begin
            waits++;
            @(negedge clk);
            chk(sel_o == first, "R6 select held", sel_o, first);
        end
        @(negedge clk);
        chk(sel_o == 7'd0, "R6 select drops", sel_o, 0);
    endtask

    initial begin
        int t, w;
        repeat (2) @(negedge clk);

        // R1: reset in single-chip mode
        do_reset(2'b00);
        chk(ready_o == 1'b1, "R1 ready after reset", ready_o, 1);
        chk(sel_o == 7'd0, "R1 sel after reset", sel_o, 0);
        access(16'h9000, t, w);
        chk(t == 4, "R1 single flash upper", t, 4);
        chk(w == 0, "R1 R8 single no stretch", w, 0);
        access(16'h1000, t, w);
        chk(t == 7, "R1 single flash not low", t, 7);

        // R1: reset in expanded mode, stretch fields at 11
        do_reset(2'b01);
        access(16'h9000, t, w);
        chk(t == 6, "R1 expanded flash off", t, 6);
        chk(w == 3, "R1 ext stretch reset", w, 3);
        access(16'h0300, t, w);
        chk(t == 5, "R1 slow region", t, 5);
        chk(w == 3, "R1 slow stretch reset", w, 3);

        // R2 R3 R4 R5 R10: vector table, slow=01 ext=10
        for (int i = 0; i < NV; i++) begin
            mode_i    = VEC[i][25:24];
            dbg_act_i = VEC[i][21];
            cfg_write({VEC[i][23], VEC[i][22], 2'b10, 2'b01});
            access(VEC[i][20:5], t, w);
            chk(t == int'(VEC[i][4:2]), $sformatf("R2 R3 R4 vec%0d target", i), t, VEC[i][4:2]);
            chk(w == int'(VEC[i][1:0]), $sformatf("R5 R7 vec%0d wait", i), w, VEC[i][1:0]);
        end

        // R3 R4 R10: every mode, enable, placement and debug setting
        for (int m = 0; m < 4; m++)
            for (int c = 0; c < 8; c++) begin
                mode_i    = 2'(m);
                dbg_act_i = c[0];
                cfg_write({c[2], c[1], 4'b0000});
                for (int p = 0; p < 8; p++) begin
                    access(PROBE[p], t, w);
                    chk(t == ref_tgt(2'(m), c[2], c[1], c[0], PROBE[p]),
                        "R3 R10 sweep decode", t, ref_tgt(2'(m), c[2], c[1], c[0], PROBE[p]));
                    chk(w == 0, "R7 sweep zero code", w, 0);
                end
            end

        // R7 R8: every stretch code in expanded and single-chip modes
        dbg_act_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            mode_i = 2'b01;
            cfg_write({2'b00, 2'(k), 2'(3 - k)});
            access(16'h4000, t, w);
            chk(w == k, "R7 ext code", w, k);
            access(16'h0280, t, w);
            chk(w == 3 - k, "R7 slow code", w, 3 - k);
            mode_i = 2'b00;
            access(16'h4000, t, w);
            chk(w == 0 && t == 7, "R8 single ignores code", w, 0);
            mode_i = 2'b10;
            access(16'h0280, t, w);
            chk(w == 0, "R8 periph ignores code", w, 0);
        end

        // R9: a strobe during a stretch is ignored
        mode_i = 2'b01;
        cfg_write(6'b00_11_00);
        addr_i = 16'h5000;
        acc_req_i = 1'b1;
        @(negedge clk);
        acc_req_i = 1'b0;
        chk(sel_o == 7'b1000000, "R9 off-chip select", sel_o, 7'b1000000);
        addr_i = 16'h0800;
        acc_req_i = 1'b1;
        @(negedge clk);
        acc_req_i = 1'b0;
        chk(sel_o == 7'b1000000 && !ready_o, "R9 select unchanged", sel_o, 7'b1000000);
        @(negedge clk);
        chk(!ready_o, "R9 still waiting", ready_o, 0);
        @(negedge clk);
        chk(ready_o && sel_o == 7'b1000000, "R9 final cycle", sel_o, 7'b1000000);
        @(negedge clk);
        chk(sel_o == 7'd0 && ready_o, "R9 no second access", sel_o, 0);
        @(negedge clk);
        chk(sel_o == 7'd0, "R9 bus idle", sel_o, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        hung = 1'b1;
        chk(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule